// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

A clocked monostable pulse generator. A valid trigger starts an output pulse that stays high for a fixed number of clock cycles, set by a parameter. This replaces the external resistor and capacitor that time an analog one-shot. The block has two trigger pins:

- `trig_rise` fires on its low-to-high transition, but only while `trig_fall` is high.
- `trig_fall` fires on its high-to-low transition, but only while `trig_rise` is low.

Both pins pass through synchronisers before their edges are detected. This lets the block accept asynchronous stimulus from anywhere in the chip.

A mode pin selects between two behaviours:

- **Retriggerable:** each valid trigger restarts the timing.
- **Non-retriggerable:** triggers that arrive while the pulse is running are ignored.

An asynchronous active-low reset overrides everything. It clears any running pulse at once. The outputs are a true pulse `q` and its complement `q_n`. The delay from a trigger to the output is the same fixed number of edges for every programmed pulse length.

Top module: `oneshot_pulse`

## Requirements
- R1: A low-to-high transition on `trig_rise` while `trig_fall` is high starts a pulse.
- R2: A high-to-low transition on `trig_fall` while `trig_rise` is low starts a pulse.
- R3: No other input change starts a pulse. This covers a rise of `trig_rise` while `trig_fall` is low, a fall of `trig_fall` while `trig_rise` is high, a fall of `trig_rise`, a rise of `trig_fall`, and both pins changing together.
- R4: A pulse lasts exactly PULSE_CYCLES clock cycles. `q` rises on the third rising clock edge after the input change. This latency does not depend on PULSE_CYCLES.
- R5: With `retrig_en` = 1 (retriggerable), a valid trigger during a pulse restarts the timing. A second trigger G cycles after the first, with G ≤ PULSE_CYCLES, gives one pulse of G + PULSE_CYCLES cycles.
- R6: With `retrig_en` = 0 (non-retriggerable), valid triggers that arrive while the pulse is running are ignored. A second trigger G ≤ PULSE_CYCLES cycles after the first leaves a single pulse of PULSE_CYCLES cycles. With G > PULSE_CYCLES, two full pulses result.
- R7: While `rst_n` is low, `q` is 0 and `q_n` is 1, regardless of the trigger pins. A running pulse is cleared at once and does not resume after release. The block starts in this state at power-up.
- R8: The pin levels present when reset is released are taken as the baseline, so holding a trigger level through release gives no pulse. A change made after the first rising clock edge following release is accepted as a trigger.
- R9: `q_n` is always the complement of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_rise | input | 1 | Trigger that fires on its rising edge, gated by `trig_fall` high |
| trig_fall | input | 1 | Trigger that fires on its falling edge, gated by `trig_rise` low |
| retrig_en | input | 1 | 1 = retriggerable, 0 = non-retriggerable |
| q | output | 1 | Pulse output, high while timing |
| q_n | output | 1 | Complement of `q` |

## Verification
The assertions assume two things about the inputs. First, `retrig_en` is steady while a pulse runs. Second, each trigger pin holds every level for at least one full clock cycle, so the synchroniser sees each edge.

The stimulus drives every pin only at falling clock edges. It keeps each level for a whole cycle or longer, and changes the mode only while the output is idle. Reset is asserted and released between falling edges, which places release before a known rising edge. This lets the recovery cases count edges exactly.

// File: rtl/oneshot_pulse.sv
module oneshot_pulse #(
  parameter int PULSE_CYCLES = 6,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_rise,
  input  logic trig_fall,
  input  logic retrig_en,
  output logic q,
  output logic q_n
);
  localparam int CW    = $clog2(PULSE_CYCLES + 1);
  localparam int RECOV = SYNC_STAGES + 1;
  localparam int RW    = $clog2(RECOV + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

  logic [SYNC_STAGES-1:0] a_sync, b_sync;
  logic                   a_prev, b_prev;
  logic [RW-1:0]          rec_cnt;
  logic [CW-1:0]          cnt;
  logic                   a_now, b_now, armed, hit, load;

  assign a_now = a_sync[SYNC_STAGES-1];
  assign b_now = b_sync[SYNC_STAGES-1];
  assign armed = (rec_cnt == RW'(RECOV));
  assign hit   = armed & ((a_now & ~a_prev & b_now) | (~b_now & b_prev & ~a_now));
  assign load  = hit & (retrig_en | (cnt == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sync <= '0;
      b_sync <= '1;
      a_prev <= 1'b0;
      b_prev <= 1'b1;
    end else begin
      a_sync <= {a_sync[SYNC_STAGES-2:0], trig_rise};
      b_sync <= {b_sync[SYNC_STAGES-2:0], trig_fall};
      a_prev <= a_now;
      b_prev <= b_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rec_cnt <= '0;
    else if (!armed) rec_cnt <= rec_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign q   = (cnt != '0);
  assign q_n = ~q;
endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
  parameter int PULSE_CYCLES = 6,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          retrig_en,
  input logic          q,
  input logic          q_n,
  input logic          armed,
  input logic          hit,
  input logic          load,
  input logic [CW-1:0] cnt
);
  // R4
  load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == CW'(PULSE_CYCLES));

  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !load) |=> cnt == $past(cnt) - CW'(1));

  // R4
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(load));

  // R6
  no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!retrig_en && cnt != '0) |=> cnt == $past(cnt) - CW'(1));

  // R8
  recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !hit);

  // R4
  bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(PULSE_CYCLES));

  // R7
  always @(posedge clk) begin
    if (!rst_n) reset_out_chk: assert (!q && q_n);
  end
endmodule

bind oneshot_pulse oneshot_pulse_chk #(.PULSE_CYCLES(PULSE_CYCLES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .retrig_en(retrig_en), .q(q), .q_n(q_n),
  .armed(armed), .hit(hit), .load(load), .cnt(cnt)
);

// File: tb/tb_oneshot_pulse.sv
module tb_oneshot_pulse;
  localparam int T = 6;

  logic clk = 1'b0;
  logic rst_n, a, b, mode;
  logic q, q_n;
  int   checks = 0, fails = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  oneshot_pulse #(.PULSE_CYCLES(T), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .trig_rise(a), .trig_fall(b),
    .retrig_en(mode), .q(q), .q_n(q_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet(input int n, input string req);
    int hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (q) hi++;
      if (q_n == q) chk(0, "R9", q_n, !q);
    end
    chk(hi == 0, req, hi, 0);
  endtask

  task automatic run_pair(input bit use_b, input bit rmode, input int g);
    int hi = 0, rises = 0, exp_hi, exp_r;
    logic prev = 1'b0;
    string req;
    mode = rmode;
    quiet(T + 4, "R3");
    @(negedge clk);
    if (use_b) b = 1'b0; else a = 1'b1;
    for (int i = 1; i <= g + T + 8; i++) begin
      @(negedge clk);
      chk(q_n == ~q, "R9", q_n, !q);
      if (i == 2) chk(q == 1'b0, "R4 latency low", q, 0);
      if (i == 3) chk(q == 1'b1, use_b ? "R2 start" : "R1 start", q, 1);
      if (q) hi++;
      if (q && !prev) rises++;
      prev = q;
      if (i == 1 || i == g + 1) begin if (use_b) b = 1'b1; else a = 1'b0; end
      if (i == g)               begin if (use_b) b = 1'b0; else a = 1'b1; end
    end
    exp_r  = (g <= T) ? 1 : 2;
    exp_hi = (g > T) ? 2 * T : (rmode ? g + T : T);
    req    = rmode ? "R5 width" : "R6 width";
    chk(hi == exp_hi, req, hi, exp_hi);
    chk(rises == exp_r, rmode ? "R5 pulses" : "R6 pulses", rises, exp_r);
  endtask

  initial begin
    a = 1'b0; b = 1'b1; mode = 1'b1; rst_n = 1'b1;
    #1 rst_n = 1'b0;
    #1 chk(q == 1'b0 && q_n == 1'b1, "R7 power-up", q, 0);
    repeat (3) @(negedge clk);
    chk(q == 1'b0 && q_n == 1'b1, "R7 power-up held", q, 0);
    rst_n = 1'b1;
    quiet(6, "R8 idle");

    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 2; m++)
        for (int g = 2; g <= T + 3; g++)
          run_pair(s[0], m[0], g);

    // R3: gated and wrong-direction edges never fire
    @(negedge clk); a = 1'b1; b = 1'b0; quiet(8, "R3 both change");
    @(negedge clk); a = 1'b0;           quiet(8, "R3 rise falls");
    @(negedge clk); a = 1'b1;           quiet(8, "R3 rise gated by low");
    @(negedge clk); b = 1'b1;           quiet(8, "R3 fall rises");
    @(negedge clk); b = 1'b0;           quiet(8, "R3 fall gated by high");
    @(negedge clk); a = 1'b0;           quiet(8, "R3 rise falls low");
    @(negedge clk); b = 1'b1;           quiet(8, "R3 back to idle");

    // R7: reset in mid-pulse clears at once and does not resume
    mode = 1'b1;
    @(negedge clk); a = 1'b1;
    repeat (5) @(negedge clk);
    chk(q == 1'b1, "R7 pulse running", q, 1);
    rst_n = 1'b0;
    #1 chk(q == 1'b0 && q_n == 1'b1, "R7 async clear", q, 0);
    a = 1'b0;
    repeat (2) @(negedge clk);
    a = 1'b1;
    chk(q == 1'b0, "R7 trigger ignored in reset", q, 0);
    @(negedge clk); rst_n = 1'b1;
    // R8: level held through release is baseline
    quiet(12, "R8 held level");
    a = 1'b0;
    quiet(6, "R3 fall after release");

    // R8: change after first edge following release is accepted
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); a = 1'b1;
    begin
      int hi = 0;
      for (int i = 0; i < T + 8; i++) begin
        @(negedge clk);
        if (q) hi++;
      end
      chk(hi == T, "R8 early trigger accepted", hi, T);
    end
    a = 1'b0;
    quiet(4, "R8 settle");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule